// File: doc/BRIEF.md
# Limited-Weight Crosstalk-Avoiding Bus Encoder

This block turns 8-bit data words into a 13-bit code for a long parallel on-chip bus. It does two things at once. It removes the coupling transitions in which neighbouring wires switch in opposite directions. It also keeps the number of wires that toggle per transfer low. The word is cut into two independent 4-bit lanes. Each lane carries 6 wires, and one grounded shield wire separates the two lanes.

Within a lane, three combinational steps run in order. First, the new nibble is XORed with the nibble accepted last time. Second, that difference selects a 6-bit codeword. Every codeword has at most two ones, and no two of its ones are neighbours. Third, the codeword is XORed into the lane's present wire state. Each one in the codeword therefore flips exactly one wire. Because no two neighbouring wires ever flip in the same transfer, opposite transitions on adjacent wires cannot occur. The encoded bus leaves through a register, one clock after the input is accepted.

Top module: `lwc_bus_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, all 13 bus bits are 0 until the first accepted word. The stored previous data is also 0, so the first word is differenced against zero.
- R2: For each lane, the difference is the lane nibble of the accepted word XOR the nibble that lane accepted last.
- R3: The codeword for difference y (0..15) is the y-th entry, counting from 0, of the 6-bit values in ascending numeric order that have at most two ones and no two adjacent ones. The table covers the first 16 such values: 0, 1, 2, 4, 5, 8, 9, 10, 16, 17, 18, 20, 32, 33, 34, 36. A difference of 0 therefore leaves the lane unchanged.
- R4: A lane's new wire state is its codeword XOR its previous wire state. It appears on the bus one clock after the cycle in which valid is high.
- R5: In a cycle with valid low, neither the bus nor the stored previous data changes. The next accepted word is differenced against the last accepted word.
- R6: Bit layout: lane 0 (data bits 3:0) drives bus bits 5:0, bit 6 is a shield held at 0, and lane 1 (data bits 7:4) drives bus bits 12:7.
- R7: In each lane, any single update flips at most two wires and never flips two adjacent wires.
- R8: The lanes are independent: a lane's output depends only on its own nibble history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 8 | Raw data word |
| valid_i | input | 1 | Accept data_i in this cycle |
| bus_o | output | 13 | Registered encoded bus |

## Verification
The assertions assume two things about the inputs: valid_i and data_i are synchronous and free of X after reset, and data_i matters only in cycles where valid_i is high. The stimulus keeps to this. It drives every input half a period away from the rising edge. Each lane nibble is swept through all 16×16 ordered pairs of previous and new value, which reaches every codeword from every history. Idle cycles are scattered between accepted words, and data_i is changed during those idle cycles to show that it is ignored.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  localparam int unsigned LANE_DW   = 4;
  localparam int unsigned LANE_CW   = 6;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned DATA_W    = LANE_DW * NUM_LANES;
  localparam int unsigned BUS_W     = NUM_LANES * LANE_CW + (NUM_LANES - 1);

  typedef logic [LANE_DW-1:0] lane_data_t;
  typedef logic [LANE_CW-1:0] lane_code_t;
endpackage

// File: rtl/lwc_codebook.sv
module lwc_codebook
  import lwc_pkg::*;
(
  input  lane_data_t diff_i,
  output lane_code_t code_o
);
  // Non-adjacent, weight<=2 words in ascending order (R3)
  always_comb begin
    unique case (diff_i)
      4'd0:  code_o = 6'b000000;
      4'd1:  code_o = 6'b000001;
      4'd2:  code_o = 6'b000010;
      4'd3:  code_o = 6'b000100;
      4'd4:  code_o = 6'b000101;
      4'd5:  code_o = 6'b001000;
      4'd6:  code_o = 6'b001001;
      4'd7:  code_o = 6'b001010;
      4'd8:  code_o = 6'b010000;
      4'd9:  code_o = 6'b010001;
      4'd10: code_o = 6'b010010;
      4'd11: code_o = 6'b010100;
      4'd12: code_o = 6'b100000;
      4'd13: code_o = 6'b100001;
      4'd14: code_o = 6'b100010;
      default: code_o = 6'b100100;
    endcase
  end
endmodule

// File: rtl/lwc_lane.sv
module lwc_lane
  import lwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  lane_data_t data_i,
  output lane_code_t lane_o
);
  lane_data_t prev_q, prev_d;
  lane_code_t wire_q, wire_d;
  lane_data_t diff;
  lane_code_t code;

  assign diff = data_i ^ prev_q;

  lwc_codebook cb_i (
    .diff_i (diff),
    .code_o (code)
  );

  always_comb begin
    prev_d = prev_q;
    wire_d = wire_q;
    if (en_i) begin
      prev_d = data_i;
      wire_d = wire_q ^ code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      wire_q <= '0;
    end else begin
      prev_q <= prev_d;
      wire_q <= wire_d;
    end
  end

  assign lane_o = wire_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(wire_q) && $stable(prev_q))); // R5
  AST_HISTORY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (prev_q == $past(data_i))); // R2
  AST_NO_ADJ_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (((wire_q ^ $past(wire_q)) & ((wire_q ^ $past(wire_q)) >> 1)) == '0)); // R7
  AST_FLIP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> ($countones(wire_q ^ $past(wire_q)) <= 2)); // R7
  AST_ZERO_DIFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (data_i == prev_q)) |=> $stable(wire_q)); // R3
endmodule

// File: rtl/lwc_bus_encoder.sv
module lwc_bus_encoder
  import lwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic [BUS_W-1:0]  bus_o
);
  localparam int unsigned STRIDE = LANE_CW + 1;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_code_t lane_out;

    lwc_lane lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (valid_i),
      .data_i (data_i[g*LANE_DW +: LANE_DW]),
      .lane_o (lane_out)
    );

    assign bus_o[g*STRIDE +: LANE_CW] = lane_out;

    if (g < NUM_LANES - 1) begin : g_shield
      assign bus_o[g*STRIDE + LANE_CW] = 1'b0; // R6
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (bus_o == '0)); // R1
endmodule

// File: tb/lwc_bus_encoder_tb_top.sv
module lwc_bus_encoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  data_i;
  logic        valid_i;
  logic [12:0] bus_o;

  int unsigned n_vec;
  int unsigned n_bad;
  bit          done;

  logic [5:0]  cb [16];
  logic [3:0]  m_prev [2];
  logic [5:0]  m_wire [2];
  logic [12:0] last_bus;

  lwc_bus_encoder dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_i  (data_i),
    .valid_i (valid_i),
    .bus_o   (bus_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [12:0] exp_bus();
    return {m_wire[1], 1'b0, m_wire[0]};
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: bus=%013b expected=%013b", req, act, exp);
    end
  endtask

  // drive at negedge, compare at next negedge
  task automatic step(input logic [7:0] d, input logic v, input string req);
    logic [12:0] flips;
    data_i  = d;
    valid_i = v;
    if (v) begin
      for (int l = 0; l < 2; l++) begin
        logic [3:0] nib;
        nib = d[l*4 +: 4];
        m_wire[l] = m_wire[l] ^ cb[nib ^ m_prev[l]];
        m_prev[l] = nib;
      end
    end
    last_bus = bus_o;
    @(negedge clk);
    check(req, bus_o, exp_bus());
    flips = bus_o ^ last_bus;
    n_vec++;
    if (((flips & (flips >> 1)) != 0) || ($countones(flips[5:0]) > 2) || ($countones(flips[12:7]) > 2)) begin
      n_bad++;
      $display("FAIL R7: flips=%013b expected=no adjacent, <=2 per lane", flips);
    end
  endtask

  initial begin
    int unsigned idx;
    n_vec = 0; n_bad = 0; done = 1'b0;
    idx = 0;
    for (int v = 0; v < 64; v++) begin
      logic [5:0] w;
      w = 6'(v);
      if (idx < 16 && $countones(w) <= 2 && (w & (w >> 1)) == 0) begin
        cb[idx] = w;
        idx++;
      end
    end
    m_prev[0] = '0; m_prev[1] = '0; m_wire[0] = '0; m_wire[1] = '0;

    rst_n = 1'b0; data_i = 8'hA5; valid_i = 1'b1;
    #35;
    check("R1 in reset", bus_o, 13'd0);
    @(negedge clk);
    rst_n = 1'b1;
    valid_i = 1'b0;
    @(negedge clk);
    check("R1 after release", bus_o, 13'd0);

    // R3: first word differenced against zero, each lane value
    for (int k = 0; k < 16; k++) begin
      step({4'(k), 4'(k)}, 1'b1, "R3 codebook");
      step({4'(k), 4'(k)}, 1'b1, "R3 zero diff");
    end

    // R2/R4/R8: all 16x16 pairs per lane, lanes on different orderings
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step({4'(b), 4'(a)}, 1'b1, "R4 set prev");
        step({4'(a ^ 9), 4'(b)}, 1'b1, "R2 pair");
        if (((a + b) % 5) == 0) begin
          step(8'(a * 17 + b * 3), 1'b0, "R5 idle");
          step(8'(~(a * 7 + b)), 1'b0, "R5 idle");
        end
      end
    end

    // R8: one lane held while the other moves
    for (int k = 0; k < 16; k++) begin
      step({4'h3, 4'(k)}, 1'b1, "R8 lane1 held");
      step({4'(k), 4'hC}, 1'b1, "R8 lane0 held");
    end

    // R6: shield stays low after many updates
    check("R6 shield", {12'd0, bus_o[6]}, 13'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule